// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor

This block is a small 8-bit processor: a four-phase control sequencer wrapped around a purely combinational ALU, an accumulator, a small general register bank and a program counter. The program sits in an external synchronous read-only memory. The memory returns the byte at `rom_addr` one clock after the address is presented. The processor has one 8-bit input port that it can sample and one 8-bit output port with a one-cycle write strobe.

Every instruction steps through the same four phases: fetch, decode, execute and store. Every opcode, including those that produce no arithmetic result, passes its operands through the ALU in the execute phase. As a result, every instruction takes exactly four clocks and program timing can be counted directly.

An instruction byte holds a 4-bit opcode in bits 7:4 and a 4-bit operand field in bits 3:0. Four opcodes carry a second byte, which is either an immediate value or a branch target or offset. The register index is operand bits 1:0 with the default four registers. The shift amount is operand bits 2:0. Calls, interrupts, writable data memory, multiply and divide are not part of the block.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears the program counter, accumulator, flags and registers. It then shows `rom_addr` = 0, `out_we` = 0 and `out_port` = 0, and it starts in the fetch phase once reset is released.
- R2: Every instruction takes exactly four clocks (fetch, decode, execute, store). Counting rising edges from reset release as 1, 2, 3, the strobe for the output instruction executed k-th (k from 0) is seen after edge 4k+4.
- R3: `out_we` is high for exactly one clock per output instruction (opcode 0xC), and `out_port` then carries the accumulator.
- R4: Opcodes 0x3 ADD, 0x4 SUB (acc minus register), 0x5 AND, 0x6 OR and 0x7 XOR combine the accumulator with register[operand] and write the result modulo 256 back to the accumulator.
- R5: Opcodes 0x8 shift right logical, 0x9 shift right arithmetic (sign-filled) and 0xA shift left logical shift the accumulator by operand bits 2:0.
- R6: Opcode 0x0 loads the second byte into the accumulator, 0x1 copies register[operand] into it, and 0x2 copies the accumulator into register[operand].
- R7: Opcode 0xB loads the value on `in_port` into the accumulator.
- R8: Opcode 0xD jumps to the absolute address given in its second byte. It always jumps when its operand field is non-zero, and jumps only if the zero flag is set when the field is zero.
- R9: Opcodes 0xE (on zero flag) and 0xF (on negative flag) add the sign-extended second byte to the address of the following instruction when their condition holds, and fall through otherwise.
- R10: Every instruction that writes the accumulator (0x0, 0x1, 0x3 to 0xB) sets the zero flag to (result == 0) and the negative flag to result bit 7. Opcodes 0x2, 0xC, 0xD, 0xE and 0xF leave both flags unchanged.
- R11: Opcodes 0x0, 0xD, 0xE and 0xF are two bytes long and all others are one byte long. Without a taken branch, the program counter advances by the instruction length, wrapping modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_addr | output | 8 | Program memory address (the program counter) |
| rom_data | input | 8 | Program memory byte, valid one clock after its address |
| in_port | input | 8 | Input port sampled by the input instruction |
| out_port | output | 8 | Output port, updated by the output instruction |
| out_we | output | 1 | One-clock strobe marking a new `out_port` value |

## Verification
Three hand-written programs come first. The first chains every ALU operation with operands chosen so that add and subtract wrap and the arithmetic shift fills with sign bits, which separates arithmetic from logical right shift and shows that only the low byte is kept. The second and third exercise absolute jumps in both forms and relative branches forward and backward. They also place an output instruction between a flag-setting load and a branch, so a core that wrongly lets non-accumulator instructions touch the flags takes the wrong path. Fully random program images, biased towards output instructions, then run long mixed sequences with wrapping jumps and loops. Each output value and the clock edge it appears on are compared against an instruction-level model in the bench, so errors in timing (R2) and in data can be told apart.

// File: rtl/acc8_pkg.sv
// Shared constants, types and decode helpers for the 8-bit accumulator core.
// Assumes: data and address are both one byte wide, so absolute targets fit a
// single immediate byte and relative offsets wrap modulo 256.
package acc8_pkg;

    localparam int DW  = 8;            // data word width
    localparam int AW  = 8;            // program address width
    localparam int OPW = 4;            // opcode field width
    localparam int FW  = DW - OPW;     // operand field width
    localparam int SHW = 3;            // shift amount width

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_STORE  = 2'd3
    } phase_e;

    typedef enum logic [OPW-1:0] {
        OP_LDI = 4'h0,
        OP_LDR = 4'h1,
        OP_STR = 4'h2,
        OP_ADD = 4'h3,
        OP_SUB = 4'h4,
        OP_AND = 4'h5,
        OP_OR  = 4'h6,
        OP_XOR = 4'h7,
        OP_SRL = 4'h8,
        OP_SRA = 4'h9,
        OP_SLL = 4'hA,
        OP_IN  = 4'hB,
        OP_OUT = 4'hC,
        OP_JMP = 4'hD,
        OP_BZR = 4'hE,
        OP_BNR = 4'hF
    } opcode_e;

    typedef struct packed {
        opcode_e         op;
        logic [FW-1:0]   arg;
    } instr_t;

    // True for opcodes followed by an immediate or target byte.
    function automatic logic has_ext(opcode_e op);
        return op inside {OP_LDI, OP_JMP, OP_BZR, OP_BNR};
    endfunction

    // True for opcodes whose ALU result lands in the accumulator.
    function automatic logic writes_acc(opcode_e op);
        return !(op inside {OP_STR, OP_OUT, OP_JMP, OP_BZR, OP_BNR});
    endfunction

endpackage

// File: rtl/acc8_alu.sv
// Combinational ALU. Every opcode passes through it; opcodes that compute
// nothing forward the accumulator unchanged so the store phase is uniform.
// Assumes: b already holds either the immediate byte or the register operand.
module acc8_alu
    import acc8_pkg::*;
(
    input  opcode_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [SHW-1:0]   shamt,
    input  logic [DW-1:0]    port_in,
    output logic [DW-1:0]    y
);

    // Select the result for the current opcode.
    always_comb begin
        case (op)
            OP_LDI, OP_LDR: y = b;
            OP_ADD:         y = a + b;
            OP_SUB:         y = a - b;
            OP_AND:         y = a & b;
            OP_OR:          y = a | b;
            OP_XOR:         y = a ^ b;
            OP_SRL:         y = a >> shamt;
            OP_SRA:         y = $signed(a) >>> shamt;
            OP_SLL:         y = a << shamt;
            OP_IN:          y = port_in;
            default:        y = a;
        endcase
    end

endmodule

// File: rtl/acc8_regfile.sv
// General register bank: NREGS bytes, one synchronous write port and one
// combinational read port. Cleared by the synchronous active-low reset.
// Assumes: 2 <= NREGS <= 16 so the index fits the instruction operand field.
module acc8_regfile
    import acc8_pkg::*;
#(
    parameter  int NREGS = 4,
    localparam int IW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [IW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] bank [NREGS];

    // Clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                bank[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NREGS; i++) begin
                if (waddr == IW'(i)) begin
                    bank[i] <= wdata;
                end
            end
        end
    end

    // Read the addressed entry.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (raddr == IW'(i)) begin
                rdata = bank[i];
            end
        end
    end

endmodule

// File: rtl/acc8_seq.sv
// Phase sequencer: cycles fetch -> decode -> execute -> store without stalls,
// giving every instruction the same four-clock length.
// Assumes: the program memory answers in exactly one clock.
module acc8_seq
    import acc8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    output phase_e   phase
);

    // Advance one phase per clock; reset returns to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
        end else begin
            case (phase)
                PH_FETCH:  phase <= PH_DECODE;
                PH_DECODE: phase <= PH_EXEC;
                PH_EXEC:   phase <= PH_STORE;
                default:   phase <= PH_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/acc8_branch.sv
// Branch resolver: decides whether the current instruction redirects the
// program counter and computes the target.
// Assumes: next_pc already points past both bytes of the instruction, and
// AW equals DW so the relative sum wraps modulo the address space.
module acc8_branch
    import acc8_pkg::*;
(
    input  opcode_e          op,
    input  logic [FW-1:0]    arg,
    input  logic             zf,
    input  logic             nf,
    input  logic [AW-1:0]    next_pc,
    input  logic [DW-1:0]    ext,
    output logic             take,
    output logic [AW-1:0]    target
);

    // Evaluate the branch condition and the destination.
    always_comb begin
        take   = 1'b0;
        target = ext;
        case (op)
            OP_JMP: begin
                take   = (arg != '0) || zf;
                target = ext;
            end
            OP_BZR: begin
                take   = zf;
                target = next_pc + ext;
            end
            OP_BNR: begin
                take   = nf;
                target = next_pc + ext;
            end
            default: begin
                take   = 1'b0;
                target = ext;
            end
        endcase
    end

endmodule

// File: rtl/acc8_core.sv
// Top level of the 8-bit accumulator core. Holds the program counter, the
// instruction and immediate latches, the accumulator, the flags and the
// output port; wires in sequencer, ALU, register bank and branch resolver.
// Assumes: rom_data is the byte at rom_addr as it was one clock earlier.
module acc8_core
    import acc8_pkg::*;
#(
    parameter  int NREGS = 4,
    localparam int RIW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   rom_addr,
    input  logic [DW-1:0]   rom_data,
    input  logic [DW-1:0]   in_port,
    output logic [DW-1:0]   out_port,
    output logic            out_we
);

    phase_e          phase;
    instr_t          ir_q;
    logic [AW-1:0]   pc_q;
    logic [DW-1:0]   acc_q;
    logic [DW-1:0]   res_q;
    logic [DW-1:0]   ext_q;
    logic            zf_q;
    logic            nf_q;

    logic [DW-1:0]   rf_rdata;
    logic [DW-1:0]   alu_b;
    logic [DW-1:0]   alu_y;
    logic            br_take;
    logic [AW-1:0]   br_target;
    logic            in_store;

    assign rom_addr = pc_q;
    assign in_store = (phase == PH_STORE);

    acc8_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    acc8_regfile #(.NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_store && (ir_q.op == OP_STR)),
        .waddr (ir_q.arg[RIW-1:0]),
        .wdata (res_q),
        .raddr (ir_q.arg[RIW-1:0]),
        .rdata (rf_rdata)
    );

    // The immediate form reads its operand straight from the memory byte.
    assign alu_b = (ir_q.op == OP_LDI) ? rom_data : rf_rdata;

    acc8_alu u_alu (
        .op      (ir_q.op),
        .a       (acc_q),
        .b       (alu_b),
        .shamt   (ir_q.arg[SHW-1:0]),
        .port_in (in_port),
        .y       (alu_y)
    );

    acc8_branch u_br (
        .op      (ir_q.op),
        .arg     (ir_q.arg),
        .zf      (zf_q),
        .nf      (nf_q),
        .next_pc (pc_q),
        .ext     (ext_q),
        .take    (br_take),
        .target  (br_target)
    );

    // Program counter: step per fetched byte, reload on a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (phase)
                PH_FETCH: pc_q <= pc_q + AW'(1);
                PH_EXEC:  if (has_ext(ir_q.op)) pc_q <= pc_q + AW'(1);
                PH_STORE: if (br_take) pc_q <= br_target;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    // Instruction latch: capture the opcode byte in decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (phase == PH_DECODE) begin
            ir_q <= instr_t'(rom_data);
        end
    end

    // Execute latches: second byte and ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
            res_q <= '0;
        end else if (phase == PH_EXEC) begin
            ext_q <= rom_data;
            res_q <= alu_y;
        end
    end

    // Accumulator and flags: written back in store for result-producing ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            zf_q  <= 1'b0;
            nf_q  <= 1'b0;
        end else if (in_store && writes_acc(ir_q.op)) begin
            acc_q <= res_q;
            zf_q  <= (res_q == '0);
            nf_q  <= res_q[DW-1];
        end
    end

    // Output port: value and a single-clock strobe per output instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_port <= '0;
            out_we   <= 1'b0;
        end else begin
            out_we <= in_store && (ir_q.op == OP_OUT);
            if (in_store && (ir_q.op == OP_OUT)) begin
                out_port <= res_q;
            end
        end
    end

endmodule

// File: rtl/acc8_core_chk.sv
// Property checker for acc8_core, attached with bind. Watches the phase
// sequence, program counter stepping, strobe shape and flag retention.
module acc8_core_chk
    import acc8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      phase,
    input  logic [OPW-1:0]  op,
    input  logic            zf,
    input  logic            nf,
    input  logic [AW-1:0]   rom_addr,
    input  logic            out_we
);

    // R1: reset leaves address zero, strobe low and the fetch phase.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rom_addr == '0 && !out_we && phase == 2'd0));

    // R2: fetch is always followed by decode.
    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase == 2'd1));

    // R2: store is always followed by the next fetch.
    a_r2_store_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> (phase == 2'd0));

    // R3: the strobe never lasts two clocks.
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R3: the strobe only follows a store phase.
    a_r3_strobe_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> ($past(phase) == 2'd3));

    // R11: each fetch advances the address by one byte.
    a_r11_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (rom_addr == AW'($past(rom_addr) + AW'(1))));

    // R10: non-accumulator instructions keep both flags.
    a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && (op == 4'h2 || op == 4'hC || op >= 4'hD))
        |=> ($stable(zf) && $stable(nf)));

endmodule

bind acc8_core acc8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .op       (ir_q.op),
    .zf       (zf_q),
    .nf       (nf_q),
    .rom_addr (rom_addr),
    .out_we   (out_we)
);

// File: tb/test_acc8_core.sv
module test_acc8_core;

    localparam int MAXC = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rom_addr;
    logic [7:0]  rom_q = 8'h00;
    logic [7:0]  in_port = 8'h00;
    logic [7:0]  out_port;
    logic        out_we;

    logic [7:0]  rom [256];

    int total = 0;
    int bad   = 0;
    int ecnt  = 0;
    int lim   = 0;
    int cap_n = 0;
    int exp_n = 0;
    logic        prev_we = 1'b0;
    logic [7:0]  cap_val [MAXC];
    int          cap_cyc [MAXC];
    logic [7:0]  exp_val [MAXC];
    int          exp_cyc [MAXC];

    always #2 clk = ~clk;   // 250 MHz

    acc8_core i_acc8_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_addr (rom_addr),
        .rom_data (rom_q),
        .in_port  (in_port),
        .out_port (out_port),
        .out_we   (out_we)
    );

    // Synchronous program memory.
    always @(posedge clk) rom_q <= rom[rom_addr];

    // Edge counter since reset release.
    always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Capture output strobes away from the active edge; R3 pulse width.
    always @(negedge clk) begin
        if (rst_n && out_we && ecnt <= lim) begin
            chk("R3 strobe preceded by low", {31'd0, prev_we}, 32'd0);
            if (cap_n < MAXC) begin
                cap_val[cap_n] = out_port;
                cap_cyc[cap_n] = ecnt;
            end
            cap_n++;
        end
        prev_we = out_we;
    end

    // Instruction-level reference model of the program.
    task automatic model(input int steps, input logic [7:0] inv);
        logic [7:0] pc = 8'h00;
        logic [7:0] a  = 8'h00;
        logic       z  = 1'b0;
        logic       n  = 1'b0;
        logic [7:0] r [4];
        for (int i = 0; i < 4; i++) r[i] = 8'h00;
        exp_n = 0;
        for (int k = 0; k < steps; k++) begin
            logic [3:0] op;
            logic [3:0] f;
            logic [7:0] nb;
            logic [7:0] nxt;
            logic [7:0] v;
            logic       wr;
            op  = rom[pc][7:4];
            f   = rom[pc][3:0];
            nb  = rom[8'(pc + 8'd1)];
            nxt = (op == 4'h0 || op >= 4'hD) ? 8'(pc + 8'd2) : 8'(pc + 8'd1);
            wr  = 1'b1;
            v   = a;
            case (op)
                4'h0: v = nb;
                4'h1: v = r[f[1:0]];
                4'h2: begin r[f[1:0]] = a; wr = 1'b0; end
                4'h3: v = 8'(a + r[f[1:0]]);
                4'h4: v = 8'(a - r[f[1:0]]);
                4'h5: v = a & r[f[1:0]];
                4'h6: v = a | r[f[1:0]];
                4'h7: v = a ^ r[f[1:0]];
                4'h8: v = a >> f[2:0];
                4'h9: begin
                    v = a >> f[2:0];
                    if (a[7]) v = v | ~(8'hFF >> f[2:0]);
                end
                4'hA: v = 8'(a << f[2:0]);
                4'hB: v = inv;
                4'hC: begin
                    wr = 1'b0;
                    if (exp_n < MAXC) begin
                        exp_val[exp_n] = a;
                        exp_cyc[exp_n] = 4 * k + 4;
                    end
                    exp_n++;
                end
                4'hD: begin wr = 1'b0; if (f != 4'h0 || z) nxt = nb; end
                4'hE: begin wr = 1'b0; if (z) nxt = 8'(nxt + nb); end
                default: begin wr = 1'b0; if (n) nxt = 8'(nxt + nb); end
            endcase
            if (wr) begin
                a = v;
                z = (v == 8'h00);
                n = v[7];
            end
            pc = nxt;
        end
    endtask

    // Reset, check reset state, run a program and compare with the model.
    task automatic run(input int steps, input logic [7:0] inv);
        rst_n = 1'b0;
        in_port = inv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rom_addr in reset", {24'd0, rom_addr}, 32'd0);
        chk("R1 out_we in reset", {31'd0, out_we}, 32'd0);
        chk("R1 out_port in reset", {24'd0, out_port}, 32'd0);
        model(steps, inv);
        cap_n = 0;
        lim = 4 * steps;
        rst_n = 1'b1;
        repeat (4 * steps + 2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        chk("R2 number of strobes", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n && i < MAXC; i++) begin
            chk($sformatf("R4 output value #%0d", i), {24'd0, cap_val[i]}, {24'd0, exp_val[i]});
            chk($sformatf("R2 output edge #%0d", i), cap_cyc[i], exp_cyc[i]);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    endtask

    task automatic poke(input int addr, input logic [7:0] b);
        rom[addr] = b;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Directed program 1: ALU, shifts, registers and input port.
        clear_rom();
        begin
            logic [7:0] p1 [25] = '{8'h00, 8'h5A, 8'h21, 8'h00, 8'hC3, 8'h22, 8'h31,
                                    8'hC0, 8'h42, 8'hC0, 8'h72, 8'hC0, 8'h93, 8'hC0,
                                    8'h82, 8'hC0, 8'hA5, 8'hC0, 8'hB0, 8'hC0, 8'h51,
                                    8'h62, 8'hC0, 8'h11, 8'hC0};
            for (int i = 0; i < 25; i++) poke(i, p1[i]);
        end
        run(24, 8'h37);
        chk("R11 strobes after mixed-length code", cap_n, 9);
        chk("R4 ADD wraps", {24'd0, cap_val[0]}, 32'h1D);
        chk("R2 first strobe edge", cap_cyc[0], 24);
        chk("R4 SUB wraps", {24'd0, cap_val[1]}, 32'h5A);
        chk("R5 SRA sign fill", {24'd0, cap_val[3]}, 32'hF3);
        chk("R5 SRL zero fill", {24'd0, cap_val[4]}, 32'h3C);
        chk("R5 SLL drops high bits", {24'd0, cap_val[5]}, 32'h80);
        chk("R7 input port", {24'd0, cap_val[6]}, 32'h37);
        chk("R4 AND then OR", {24'd0, cap_val[7]}, 32'hD3);
        chk("R6 register read back", {24'd0, cap_val[8]}, 32'h5A);
        chk("R2 last strobe edge", cap_cyc[8], 92);

        // Directed program 2: conditional absolute jump, relative branches.
        clear_rom();
        poke(8'h00, 8'h00); poke(8'h01, 8'h00); poke(8'h02, 8'hC0);
        poke(8'h03, 8'hD0); poke(8'h04, 8'h10);
        poke(8'h05, 8'h00); poke(8'h06, 8'hEE); poke(8'h07, 8'hC0);
        poke(8'h10, 8'h00); poke(8'h11, 8'h80);
        poke(8'h12, 8'hE0); poke(8'h13, 8'h05);
        poke(8'h14, 8'hF0); poke(8'h15, 8'h03);
        poke(8'h16, 8'h00); poke(8'h17, 8'h11); poke(8'h18, 8'hC0);
        poke(8'h19, 8'hC0);
        poke(8'h1A, 8'h00); poke(8'h1B, 8'h01); poke(8'h1C, 8'hC0);
        poke(8'h1D, 8'hA7); poke(8'h1E, 8'hF0); poke(8'h1F, 8'hF4);
        run(20, 8'h00);
        chk("R10 zero output keeps flag", {24'd0, cap_val[0]}, 32'h00);
        chk("R2 strobe edge of second instr", cap_cyc[0], 8);
        chk("R8 conditional jump taken on Z", {24'd0, cap_val[1]}, 32'h80);
        chk("R9 BNR forward skip timing", cap_cyc[1], 28);
        chk("R9 backward branch loops", {24'd0, cap_val[3]}, 32'h80);
        chk("R9 backward branch timing", cap_cyc[3], 52);

        // Directed program 3: unconditional absolute jump with Z clear.
        clear_rom();
        poke(0, 8'h00); poke(1, 8'h01); poke(2, 8'hD1); poke(3, 8'h08);
        poke(4, 8'hC0); poke(8, 8'h00); poke(9, 8'h42); poke(10, 8'hC0);
        run(6, 8'h00);
        chk("R8 unconditional jump value", {24'd0, cap_val[0]}, 32'h42);
        chk("R8 unconditional jump timing", cap_cyc[0], 16);

        // Random program images, biased towards output instructions.
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < 256; i++) begin
                rom[i] = ($urandom_range(0, 3) == 0) ? 8'hC0 : 8'($urandom);
            end
            run(300, 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule